// File: doc/BRIEF.md
# Smart Panel Register Access Engine

This engine carries single register reads and writes between a host and a smart display panel. The panel sits on an 18-line parallel bus of the 8080 type, with chip select, register select, a write strobe, a read strobe and bidirectional data lines. The host presents one request: a direction flag, a 16-bit register address, 16-bit write data and a set of timing counts in clock cycles. When the transfer ends the engine pulses `done`. For a read, it returns the 16-bit value on `rd_data`.

A 16-bit word does not fill the bus evenly. Each byte takes an 8-line lane, and the line below each lane stays unused. A write has two bus cycles. The first is a command cycle that carries the address. The second is a data cycle that carries the value. Each strobe phase has its own setup and hold count. A read has no native hardware path. The engine therefore latches the address with a write strobe, releases the data lines and then pulses the read strobe twice. It samples the panel during the second low phase.

The bidirectional lines appear as separate output, output-enable and input vectors, and a pad ring joins them. A watchdog in the engine reports a request that is held pending for too long while a transfer is running.

Top module: `lcd_reg_engine`

## Requirements
- R1: A word driven onto the bus places bits 7..0 on lines 8..1 and bits 15..8 on lines 17..10, with lines 0 and 9 at zero.
- R2: A read result takes bits 7..0 from lines 8..1 and bits 15..8 from lines 17..10, and lines 0 and 9 have no effect on it.
- R3: A write has two steps with chip select low. The first is a command cycle: register select low, address driven, write strobe low then high. The second is a data cycle: register select high, value driven, write strobe low then high. The driven word stays unchanged across each rising write strobe.
- R4: In a write, the strobe-low time is the setup count and the strobe-high time is the hold count, in cycles. A count of zero selects the default: command setup 2, command hold 2, data setup 1, data hold 2.
- R5: A read moves the pins (cs_n, rs, wr_n, rd_n, oe) through these vectors from idle 11110: 10110, 00110, 00011, 00111, 00110, 00100, 01100, 01110, 01100, 01110, and then back to 11110. Each vector lasts the read step count in cycles, and a step count of zero means 1.
- R6: The data output enable is low for at least one cycle before the read strobe falls, and it stays low while the read strobe is low.
- R7: Read data is captured in the last cycle of the second read-strobe low phase. It stays on `rd_data` until the next read completes, and writes do not change it.
- R8: A request is accepted only in a cycle where `req_valid` is high and `busy` is low. `busy` stays high until the transfer's last bus step ends. A request offered while busy is not taken. `done` is a single-cycle pulse in the first cycle in which `busy` is low again.
- R9: The timing counts are captured at acceptance. Changing the count inputs during a transfer does not affect that transfer.
- R10: If `req_valid` is high while `busy` is high for TIMEOUT_CYC consecutive cycles, `req_abort` pulses for one cycle and the count restarts.
- R11: After reset, cs_n, rs, wr_n and rd_n are high, oe is low, and busy, done and req_abort are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 16 | Panel register address |
| req_wdata | input | 16 | Value to write |
| cfg_cmd_setup | input | 4 | Command-cycle strobe-low cycles (0 = default 2) |
| cfg_cmd_hold | input | 4 | Command-cycle strobe-high cycles (0 = default 2) |
| cfg_dat_setup | input | 4 | Data-cycle strobe-low cycles (0 = default 1) |
| cfg_dat_hold | input | 4 | Data-cycle strobe-high cycles (0 = default 2) |
| cfg_rd_step | input | 4 | Cycles per read-sequence step (0 = 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read result |
| req_abort | output | 1 | Pending request timed out |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_dq_out | output | 18 | Data lines driven toward the panel |
| lcd_dq_oe | output | 1 | Data line output enable |
| lcd_dq_in | input | 18 | Data lines as seen from the panel |

## Verification
A wrong phase or a wrong step counter in the sequencer shows up at the pins within one cycle: a pin vector out of order, or a phase whose length differs from its count. Both appear in the bench's log of run lengths well before `done`. A lane shift or a swapped byte corrupts the word seen at the next rising write strobe, or the result of the next read, by the end of that transfer. A turnaround fault, where the output enable is still high when the read strobe falls, is caught in that same cycle. A faulty timeout counter gives an abort pulse on the wrong cycle, which the bench sees as soon as the pulse occurs.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    parameter int WORD_W     = 16;
    parameter int LANE_BYTES = WORD_W / 8;
    parameter int BUS_W      = LANE_BYTES * 9;
    parameter int TCW        = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BUS_W-1:0]  bus_t;
    typedef logic [TCW-1:0]    tcnt_t;

    localparam tcnt_t DEF_CMD_SU = tcnt_t'(2);
    localparam tcnt_t DEF_CMD_HD = tcnt_t'(2);
    localparam tcnt_t DEF_DAT_SU = tcnt_t'(1);
    localparam tcnt_t DEF_DAT_HD = tcnt_t'(2);

    typedef struct packed {
        tcnt_t cmd_su;
        tcnt_t cmd_hd;
        tcnt_t dat_su;
        tcnt_t dat_hd;
        tcnt_t rd_step;
    } tcfg_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_WC_SU, PH_WC_HD, PH_WD_SU, PH_WD_HD,
        PH_R_RS, PH_R_CS, PH_R_WL, PH_R_WH, PH_R_TURN,
        PH_R_RD1, PH_R_RSH, PH_R_RDH1, PH_R_RD2, PH_R_RDH2
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic rs;
        logic wr_n;
        logic rd_n;
        logic oe;
        logic use_wdata;
    } pins_t;

    function automatic tcnt_t or_default(tcnt_t v, tcnt_t d);
        return (v == '0) ? d : v;
    endfunction

    // Fixed chain of phases; both chains return to idle.
    function automatic phase_e next_phase(phase_e p);
        case (p)
            PH_WC_SU:  return PH_WC_HD;
            PH_WC_HD:  return PH_WD_SU;
            PH_WD_SU:  return PH_WD_HD;
            PH_R_RS:   return PH_R_CS;
            PH_R_CS:   return PH_R_WL;
            PH_R_WL:   return PH_R_WH;
            PH_R_WH:   return PH_R_TURN;
            PH_R_TURN: return PH_R_RD1;
            PH_R_RD1:  return PH_R_RSH;
            PH_R_RSH:  return PH_R_RDH1;
            PH_R_RDH1: return PH_R_RD2;
            PH_R_RD2:  return PH_R_RDH2;
            default:   return PH_IDLE;
        endcase
    endfunction

    // Length of a phase in cycles, never zero outside idle.
    function automatic tcnt_t phase_len(phase_e p, tcfg_t c);
        case (p)
            PH_IDLE:  return '0;
            PH_WC_SU: return or_default(c.cmd_su, DEF_CMD_SU);
            PH_WC_HD: return or_default(c.cmd_hd, DEF_CMD_HD);
            PH_WD_SU: return or_default(c.dat_su, DEF_DAT_SU);
            PH_WD_HD: return or_default(c.dat_hd, DEF_DAT_HD);
            default:  return or_default(c.rd_step, tcnt_t'(1));
        endcase
    endfunction

    // Pin levels per phase: cs_n, rs, wr_n, rd_n, oe, use_wdata.
    function automatic pins_t phase_pins(phase_e p);
        case (p)
            PH_WC_SU:  return 6'b000110;
            PH_WC_HD:  return 6'b001110;
            PH_WD_SU:  return 6'b010111;
            PH_WD_HD:  return 6'b011111;
            PH_R_RS:   return 6'b101100;
            PH_R_CS:   return 6'b001100;
            PH_R_WL:   return 6'b000110;
            PH_R_WH:   return 6'b001110;
            PH_R_TURN: return 6'b001100;
            PH_R_RD1:  return 6'b001000;
            PH_R_RSH:  return 6'b011000;
            PH_R_RDH1: return 6'b011100;
            PH_R_RD2:  return 6'b011000;
            PH_R_RDH2: return 6'b011100;
            default:   return 6'b111100;
        endcase
    endfunction

endpackage

// File: rtl/lcd_lane_map.sv
module lcd_lane_map
    import lcd_pkg::*;
#(
    parameter int NBYTES = LANE_BYTES
) (
    input  logic [NBYTES*8-1:0] word_in,
    output logic [NBYTES*9-1:0] bus_out,
    input  logic [NBYTES*9-1:0] bus_in,
    output logic [NBYTES*8-1:0] word_out,
    output logic [NBYTES-1:0]   gap_in
);
    // Each byte occupies a 9-line lane whose lowest line is a spare.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign bus_out[b*9]          = 1'b0;
        assign bus_out[b*9+1 +: 8]   = word_in[b*8 +: 8];
        assign word_out[b*8 +: 8]    = bus_in[b*9+1 +: 8];
        assign gap_in[b]             = bus_in[b*9];
    end
endmodule

// File: rtl/lcd_seq_fsm.sv
module lcd_seq_fsm
    import lcd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   start_wr,
    input  tcfg_t  cfg_in,
    output phase_e phase,
    output logic   sample_now,
    output logic   finish
);
    phase_e ph_q;
    tcnt_t  cnt_q;
    tcfg_t  cfg_q;
    phase_e first_ph;
    phase_e nxt_ph;
    logic   last;

    assign first_ph = start_wr ? PH_WC_SU : PH_R_RS;
    assign nxt_ph   = next_phase(ph_q);
    assign last     = (cnt_q == tcnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            cfg_q <= '0;
        end else if (ph_q == PH_IDLE) begin
            if (start) begin
                ph_q  <= first_ph;
                cnt_q <= phase_len(first_ph, cfg_in);
                cfg_q <= cfg_in;
            end
        end else if (last) begin
            ph_q  <= nxt_ph;
            cnt_q <= phase_len(nxt_ph, cfg_q);
        end else begin
            cnt_q <= cnt_q - tcnt_t'(1);
        end
    end

    assign phase      = ph_q;
    assign sample_now = (ph_q == PH_R_RD2) && last;
    assign finish     = (ph_q != PH_IDLE) && last && (nxt_ph == PH_IDLE);

    // R4: every active phase lasts at least one cycle
    assert_len_min_R4: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE) |-> (cnt_q != '0));

    // R8: leaving idle happens only on an accepted start
    assert_start_only_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(ph_q) == PH_IDLE && ph_q != PH_IDLE) |-> $past(start));

    // R9: captured timing is frozen while a transfer runs
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE && $past(ph_q) != PH_IDLE) |-> $stable(cfg_q));
endmodule

// File: rtl/lcd_req_guard.sv
module lcd_req_guard #(
    parameter int TIMEOUT_CYC = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic busy,
    output logic abort
);
    localparam int TOW = $clog2(TIMEOUT_CYC + 1);

    logic [TOW-1:0] wait_q;
    logic           abort_q;
    logic           waiting;

    assign waiting = req_valid && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q  <= '0;
            abort_q <= 1'b0;
        end else if (waiting && wait_q == TOW'(TIMEOUT_CYC - 1)) begin
            wait_q  <= '0;
            abort_q <= 1'b1;
        end else begin
            wait_q  <= waiting ? wait_q + TOW'(1) : '0;
            abort_q <= 1'b0;
        end
    end

    assign abort = abort_q;

    // R10: an abort follows a cycle in which a request was pending
    assert_abort_waiting_R10: assert property (@(posedge clk) disable iff (rst)
        abort |-> $past(req_valid && busy));

    // R10: the abort is a single-cycle pulse
    assert_abort_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        abort |=> !abort);
endmodule

// File: rtl/lcd_reg_engine.sv
module lcd_reg_engine
    import lcd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [WORD_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [TCW-1:0]    cfg_cmd_setup,
    input  logic [TCW-1:0]    cfg_cmd_hold,
    input  logic [TCW-1:0]    cfg_dat_setup,
    input  logic [TCW-1:0]    cfg_dat_hold,
    input  logic [TCW-1:0]    cfg_rd_step,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              req_abort,
    output logic              lcd_cs_n,
    output logic              lcd_rs,
    output logic              lcd_wr_n,
    output logic              lcd_rd_n,
    output logic [BUS_W-1:0]  lcd_dq_out,
    output logic              lcd_dq_oe,
    input  logic [BUS_W-1:0]  lcd_dq_in
);
    phase_e ph;
    pins_t  pins;
    tcfg_t  cfg_now;
    word_t  addr_q, wdata_q, rdata_q, drive_word, bus_word;
    bus_t   mapped;
    logic   [LANE_BYTES-1:0] gap_bits;
    logic   accept, sample_now, finish, done_q;
    logic   unused_gap;

    assign cfg_now = '{cmd_su: cfg_cmd_setup, cmd_hd: cfg_cmd_hold,
                       dat_su: cfg_dat_setup, dat_hd: cfg_dat_hold,
                       rd_step: cfg_rd_step};

    assign busy   = (ph != PH_IDLE);
    assign accept = req_valid && !busy;

    lcd_seq_fsm u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_wr   (req_write),
        .cfg_in     (cfg_now),
        .phase      (ph),
        .sample_now (sample_now),
        .finish     (finish)
    );

    lcd_req_guard #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .busy      (busy),
        .abort     (req_abort)
    );

    assign pins       = phase_pins(ph);
    assign drive_word = pins.use_wdata ? wdata_q : addr_q;

    lcd_lane_map #(.NBYTES(LANE_BYTES)) u_map (
        .word_in  (drive_word),
        .bus_out  (mapped),
        .bus_in   (lcd_dq_in),
        .word_out (bus_word),
        .gap_in   (gap_bits)
    );

    assign unused_gap = ^gap_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (sample_now) begin
                rdata_q <= bus_word;
            end
            done_q <= finish;
        end
    end

    assign lcd_cs_n   = pins.cs_n;
    assign lcd_rs     = pins.rs;
    assign lcd_wr_n   = pins.wr_n;
    assign lcd_rd_n   = pins.rd_n;
    assign lcd_dq_oe  = pins.oe;
    assign lcd_dq_out = pins.oe ? mapped : '0;
    assign done       = done_q;
    assign rd_data    = rdata_q;

    // R1: spare lines stay low whenever the bus is driven
    assert_gap_low_R1: assert property (@(posedge clk) disable iff (rst)
        lcd_dq_oe |-> (lcd_dq_out[0] == 1'b0 && lcd_dq_out[9] == 1'b0));

    // R3: the driven word holds across the rising write strobe
    assert_hold_word_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_wr_n) |-> (lcd_dq_oe && $stable(lcd_dq_out)));

    // R5: strobes never overlap and need chip select
    assert_strobe_cs_R5: assert property (@(posedge clk) disable iff (rst)
        (!lcd_wr_n || !lcd_rd_n) |-> (!lcd_cs_n && (lcd_wr_n || lcd_rd_n)));

    // R6: bus released at least one cycle before and during read strobe
    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        !lcd_rd_n |-> (!lcd_dq_oe && !$past(lcd_dq_oe)));

    // R8: done marks the end of a busy period
    assert_done_end_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
endmodule

// File: tb/sim_lcd_reg_engine.sv
module sim_lcd_reg_engine;
    localparam int CLK_P = 10;
    localparam int TO_CYC = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [3:0] cfg_cmd_setup = '0, cfg_cmd_hold = '0, cfg_dat_setup = '0, cfg_dat_hold = '0, cfg_rd_step = '0;
    logic busy, done, req_abort, lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_dq_oe;
    logic [15:0] rd_data;
    logic [17:0] lcd_dq_out, lcd_dq_in;

    int checks = 0, failures = 0;

    always #(CLK_P/2) clk = ~clk;

    lcd_reg_engine #(.TIMEOUT_CYC(TO_CYC)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_cmd_setup(cfg_cmd_setup), .cfg_cmd_hold(cfg_cmd_hold),
        .cfg_dat_setup(cfg_dat_setup), .cfg_dat_hold(cfg_dat_hold),
        .cfg_rd_step(cfg_rd_step), .busy(busy), .done(done), .rd_data(rd_data),
        .req_abort(req_abort), .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs),
        .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_dq_out(lcd_dq_out),
        .lcd_dq_oe(lcd_dq_oe), .lcd_dq_in(lcd_dq_in)
    );

    function automatic logic [17:0] b_map(logic [15:0] w);
        return {w[15:8], 1'b0, w[7:0], 1'b0};
    endfunction

    function automatic logic [15:0] b_unmap(logic [17:0] b);
        return {b[17:10], b[8:1]};
    endfunction

    function automatic int eff(logic [3:0] v, int d);
        return (v == 0) ? d : int'(v);
    endfunction

    // Panel model
    logic [15:0] pmem [logic [15:0]];
    logic [15:0] pan_addr = '0, rd_word_q = '0, cap_cmd = '0, cap_dat = '0;
    bit gap_bad = 0;
    int wr_rises = 0;

    function automatic logic [15:0] panel_val(logic [15:0] a);
        return pmem.exists(a) ? pmem[a] : (a ^ 16'hA5C3);
    endfunction

    assign lcd_dq_in = !lcd_rd_n ? (b_map(rd_word_q) | 18'h00201) : 18'h15555;

    // Pin-vector run-length log: {cs_n, rs, wr_n, rd_n, oe}
    logic [4:0] log_vec [32];
    int log_dur [32];
    int log_n = 0, run = 0;
    logic [4:0] prev_vec = 5'b11110;
    logic prev_wr = 1'b1;

    always @(negedge clk) begin
        logic [4:0] cur;
        cur = {lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_dq_oe};
        if (cur != prev_vec) begin
            if (log_n < 32) begin
                log_vec[log_n] = prev_vec;
                log_dur[log_n] = run;
            end
            log_n++;
            run = 1;
            prev_vec = cur;
        end else begin
            run++;
        end
        if (!prev_wr && lcd_wr_n && !rst) begin
            wr_rises++;
            if (lcd_dq_out[0] || lcd_dq_out[9]) gap_bad = 1;
            if (!lcd_rs) begin
                pan_addr = b_unmap(lcd_dq_out);
                cap_cmd = pan_addr;
                rd_word_q = panel_val(pan_addr);
            end else begin
                cap_dat = b_unmap(lcd_dq_out);
                pmem[pan_addr] = cap_dat;
            end
        end
        prev_wr = lcd_wr_n;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // mode: 0 plain, 1 change cfg mid-transfer, 2 offer a second request while busy, 3 hold request for timeout
    task automatic do_xfer(input bit wr, input logic [15:0] a, input logic [15:0] d,
                           input logic [3:0] csu, input logic [3:0] chd, input logic [3:0] dsu,
                           input logic [3:0] dhd, input logic [3:0] rs, input int mode, input string lbl);
        int guard;
        int wait_cnt;
        int aborts;
        int rises0;
        logic [4:0] exp_v [10];
        int exp_d [10];
        int nsteps;
        logic [15:0] exp_rd;
        @(negedge clk);
        while (busy) @(negedge clk);
        exp_rd = panel_val(a);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cfg_cmd_setup = csu; cfg_cmd_hold = chd; cfg_dat_setup = dsu; cfg_dat_hold = dhd; cfg_rd_step = rs;
        log_n = 0;
        gap_bad = 0;
        rises0 = wr_rises;
        @(negedge clk);
        req_valid = (mode == 3);
        if (mode == 1) begin
            cfg_cmd_setup = 4'd9; cfg_cmd_hold = 4'd9; cfg_dat_setup = 4'd9;
            cfg_dat_hold = 4'd9; cfg_rd_step = 4'd9;
        end
        if (mode == 2) begin
            chk(busy == 1'b1, "R8 busy after accept", busy, 1);
            req_valid = 1'b1; req_addr = a ^ 16'h0F0F;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_cnt = 0; aborts = 0; guard = 0;
        forever begin
            if (mode == 3) begin
                if (req_abort) begin
                    aborts++;
                    chk(wait_cnt == TO_CYC, "R10 abort after pending cycles", wait_cnt, TO_CYC);
                    req_valid = 1'b0;
                end else if (req_valid && busy) begin
                    wait_cnt++;
                end
            end
            if (done) break;
            @(negedge clk);
            guard++;
            if (guard > 4000) begin
                chk(0, "R8 done never seen", 0, 1);
                break;
            end
        end
        #1;
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
        if (mode == 3) chk(aborts == 1, "R10 single abort pulse", aborts, 1);
        if (wr) begin
            nsteps = 4;
            exp_v[0] = 5'b00011; exp_d[0] = eff(csu, 2);
            exp_v[1] = 5'b00111; exp_d[1] = eff(chd, 2);
            exp_v[2] = 5'b01011; exp_d[2] = eff(dsu, 1);
            exp_v[3] = 5'b01111; exp_d[3] = eff(dhd, 2);
            chk(cap_cmd == a, "R3 address on command cycle", cap_cmd, a);
            chk(cap_dat == d, "R1 value on data lanes", cap_dat, d);
            chk(!gap_bad, "R1 spare lines zero", gap_bad, 0);
        end else begin
            nsteps = 10;
            exp_v[0] = 5'b10110; exp_v[1] = 5'b00110; exp_v[2] = 5'b00011;
            exp_v[3] = 5'b00111; exp_v[4] = 5'b00110; exp_v[5] = 5'b00100;
            exp_v[6] = 5'b01100; exp_v[7] = 5'b01110; exp_v[8] = 5'b01100;
            exp_v[9] = 5'b01110;
            for (int i = 0; i < 10; i++) exp_d[i] = eff(rs, 1);
            chk(cap_cmd == a, "R5 read address latched", cap_cmd, a);
            chk(rd_data == exp_rd, "R2 read value rebuilt", rd_data, exp_rd);
        end
        chk(log_n == nsteps + 1, {lbl, " step count"}, log_n, nsteps + 1);
        for (int i = 0; i < nsteps; i++) begin
            if (i + 1 < log_n && i + 1 < 32) begin
                chk(log_vec[i+1] == exp_v[i], $sformatf("%s pins step %0d", lbl, i), log_vec[i+1], exp_v[i]);
                chk(log_dur[i+1] == exp_d[i], $sformatf("%s length step %0d", lbl, i), log_dur[i+1], exp_d[i]);
            end
        end
        chk({lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_dq_oe} == 5'b11110, "R5 idle pins after transfer",
            {lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_dq_oe}, 5'b11110);
        @(negedge clk);
        chk(done == 1'b0, "R8 done is one cycle", done, 0);
        if (mode == 2) begin
            repeat (5) @(negedge clk);
            chk(busy == 1'b0, "R8 request during busy not taken", busy, 0);
            chk(wr_rises - rises0 == 2, "R8 no extra bus cycle", wr_rises - rises0, 2);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL R8 watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] a, d, held;
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk({lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_dq_oe} == 5'b11110, "R11 reset pins",
            {lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_dq_oe}, 5'b11110);
        chk({busy, done, req_abort} == 3'b000, "R11 reset flags", {busy, done, req_abort}, 0);

        // Directed: defaults (R4), extreme patterns, zero read step
        do_xfer(1, 16'h00E5, 16'h78F0, 0, 0, 0, 0, 0, 0, "R4 default timing");
        do_xfer(0, 16'h00E5, 16'h0000, 0, 0, 0, 0, 0, 0, "R5 R6 read zero step");
        do_xfer(1, 16'hFFFF, 16'hFFFF, 1, 1, 1, 1, 1, 0, "R3 write all ones");
        do_xfer(0, 16'hFFFF, 16'h0000, 0, 0, 0, 0, 3, 0, "R5 R6 read step 3");
        do_xfer(1, 16'h0000, 16'h0000, 4, 3, 2, 1, 1, 0, "R3 write all zeros");
        do_xfer(0, 16'h0000, 16'h0000, 0, 0, 0, 0, 1, 0, "R5 read zero word");
        // R2 unwritten address through panel default
        do_xfer(0, 16'h1234, 16'h0000, 0, 0, 0, 0, 2, 0, "R5 read unwritten");
        // R7 read result held across a write
        held = rd_data;
        do_xfer(1, 16'h0042, 16'hBEEF, 2, 2, 2, 2, 2, 0, "R3 write after read");
        chk(rd_data == held, "R7 read data held across write", rd_data, held);
        // R9 timing captured at accept
        do_xfer(1, 16'h0101, 16'h5A5A, 3, 1, 2, 4, 1, 1, "R9 write cfg captured");
        do_xfer(0, 16'h0101, 16'h0000, 0, 0, 0, 0, 2, 1, "R9 read cfg captured");
        // R8 request during busy
        do_xfer(1, 16'h0202, 16'h1357, 5, 5, 5, 5, 1, 2, "R8 write busy");
        // R10 timeout of a pending request
        do_xfer(1, 16'h0303, 16'h2468, 15, 15, 15, 15, 1, 3, "R10 long write");

        // Random write / read-back pairs
        for (int n = 0; n < 20; n++) begin
            a = 16'($urandom);
            d = 16'($urandom);
            do_xfer(1, a, d, 4'($urandom_range(0, 4)), 4'($urandom_range(0, 4)),
                    4'($urandom_range(0, 4)), 4'($urandom_range(0, 4)), 1, 0, "R4 random write");
            do_xfer(0, a, 16'h0, 0, 0, 0, 0, 4'($urandom_range(0, 4)), 0, "R5 random read");
            chk(rd_data == d, "R2 read back written value", rd_data, d);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule